// File: doc/BRIEF.md
# Nibble-Wide Stored-Program Core

A small stored-program processor that works on 4-bit values. Program and data share one memory of sixteen 4-bit cells, so an instruction can overwrite the operand of another instruction. The architectural state is an instruction pointer, a register that holds the opcode last fetched, and two general registers, R0 and R1. The core completes one instruction per clock. An instruction is either one nibble long (opcodes 0 to 7) or two nibbles long (opcodes 8 to 15), and the second nibble is its operand.

Memory is filled through a load port while reset is held. When reset is released, the core starts at address 0 and runs until it reaches a halt opcode. It reports results through a print port that has a one-cycle valid strobe, a one-cycle bell pulse and a halted status level.

Top module: `nib_core`

## Requirements
- R1: While rst_n is low, the instruction pointer, the opcode register, R0, R1 and halted are cleared, and print_valid and bell are low. On entry to reset, every memory cell is cleared unless load_en is already high.
- R2: While rst_n is low and load_en is high, the cell at load_addr takes load_data on the clock edge. Cells loaded this way survive the rest of the reset period. While the core runs (rst_n high), load_en has no effect on memory.
- R3: One instruction completes per clock. Opcodes 0 to 7 advance the pointer by 1. Opcodes 8 to 15 take their operand from the next cell (address wraps modulo 16) and advance the pointer by 2, also modulo 16.
- R4: Opcode 1 sets R0 to R0+R1 and opcode 2 sets R0 to R0-R1. Opcodes 3 and 4 increment R0 and R1, and opcodes 5 and 6 decrement R0 and R1. All results wrap modulo 16.
- R5: Opcode 7 raises bell for exactly the one cycle after the clock edge that executes it, without a print.
- R6: Opcode 8 raises print_valid for the one cycle after the clock edge that executes it, with print_data equal to its operand nibble. print_valid and bell are never high together.
- R7: Opcodes 9 and 10 load R0 and R1 from the cell that the operand addresses. Opcodes 11 and 12 write R0 and R1 to that cell, and that cell may hold another instruction's operand.
- R8: Opcode 13 jumps to the operand address. Opcode 14 jumps only when R0 is 0, and opcode 15 jumps only when R0 is not 0. When a conditional jump is not taken, the pointer advances by 2.
- R9: Opcode 0 raises halted one cycle after the edge that executes it. halted then stays high, with no print or bell, until reset.
- R10: The program 8 0 3 11 1 15 0 placed at address 0 prints 0 to 15 in order, one print every 4 cycles, and then halts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the window for loading memory |
| load_en | input | 1 | Write strobe for loading memory, honoured only in reset |
| load_addr | input | 4 | Cell address for a load |
| load_data | input | 4 | Nibble to load |
| print_valid | output | 1 | One-cycle strobe for a print result |
| print_data | output | 4 | Printed nibble |
| bell | output | 1 | One-cycle bell pulse |
| halted | output | 1 | Core has stopped on opcode 0 |

## Verification
The checker assumes that rst_n is held low for at least one clock before any program runs, so every registered output starts from a known value. It also assumes the inputs change only between clock edges. The bench drives rst_n and the load port on falling edges. It holds reset for two clocks with load_en low before it streams a program in, so the memory clear on reset entry always happens before loading. Its only writes through the load port while the core is running are deliberate ones, made to show that they are ignored.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int W     = 4;
    localparam int DEPTH = 1 << W;

    typedef logic [W-1:0] nib_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC, ALU_LOAD
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_NONE, DST_R0, DST_R1
    } dst_e;

    typedef enum logic [1:0] {
        BR_NONE, BR_ALWAYS, BR_ZERO, BR_NZERO
    } br_e;

    typedef struct packed {
        logic    two_nib;
        logic    halt;
        logic    ring;
        logic    print;
        logic    mem_wr;
        logic    wr_from_r1;
        logic    a_is_r1;
        dst_e    dst;
        alu_op_e alu;
        br_e     br;
    } ctl_t;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        nib_t ip;
        nib_t ir;
        nib_t r0;
        nib_t r1;
        logic halted;
        logic prn_v;
        nib_t prn_d;
        logic bell;
        logic loading;
    } core_st_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  nib_t op,
    output ctl_t ctl
);
    always_comb begin
        ctl         = '0;
        ctl.two_nib = op[W-1];
        unique case (op)
            4'd0:  ctl.halt = 1'b1;
            4'd1:  begin ctl.dst = DST_R0; ctl.alu = ALU_ADD; end
            4'd2:  begin ctl.dst = DST_R0; ctl.alu = ALU_SUB; end
            4'd3:  begin ctl.dst = DST_R0; ctl.alu = ALU_INC; end
            4'd4:  begin ctl.dst = DST_R1; ctl.alu = ALU_INC; ctl.a_is_r1 = 1'b1; end
            4'd5:  begin ctl.dst = DST_R0; ctl.alu = ALU_DEC; end
            4'd6:  begin ctl.dst = DST_R1; ctl.alu = ALU_DEC; ctl.a_is_r1 = 1'b1; end
            4'd7:  ctl.ring = 1'b1;
            4'd8:  ctl.print = 1'b1;
            4'd9:  begin ctl.dst = DST_R0; ctl.alu = ALU_LOAD; end
            4'd10: begin ctl.dst = DST_R1; ctl.alu = ALU_LOAD; end
            4'd11: ctl.mem_wr = 1'b1;
            4'd12: begin ctl.mem_wr = 1'b1; ctl.wr_from_r1 = 1'b1; end
            4'd13: ctl.br = BR_ALWAYS;
            4'd14: ctl.br = BR_ZERO;
            4'd15: ctl.br = BR_NZERO;
            default: ctl.halt = 1'b1;
        endcase
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
(
    input  alu_op_e op,
    input  nib_t    a,
    input  nib_t    b,
    input  nib_t    m,
    output nib_t    y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_INC:  y = a + nib_t'(1);
            ALU_DEC:  y = a - nib_t'(1);
            default:  y = m;
        endcase
    end
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic [3:0] load_addr,
    input  logic [3:0] load_data,
    output logic       print_valid,
    output logic [3:0] print_data,
    output logic       bell,
    output logic       halted
);
    core_st_t st_q, st_d;

    nib_t op, arg, mem_at_arg, alu_a, alu_y, ip_seq;
    ctl_t ctl;
    logic take_br;

    assign op         = st_q.mem[st_q.ip];
    assign arg        = st_q.mem[st_q.ip + nib_t'(1)];
    assign mem_at_arg = st_q.mem[arg];
    assign alu_a      = ctl.a_is_r1 ? st_q.r1 : st_q.r0;
    assign ip_seq     = st_q.ip + nib_t'(ctl.two_nib ? 2 : 1);

    nib_decode u_dec (
        .op  (op),
        .ctl (ctl)
    );

    nib_alu u_alu (
        .op (ctl.alu),
        .a  (alu_a),
        .b  (st_q.r1),
        .m  (mem_at_arg),
        .y  (alu_y)
    );

    always_comb begin
        unique case (ctl.br)
            BR_ALWAYS: take_br = 1'b1;
            BR_ZERO:   take_br = (st_q.r0 == '0);
            BR_NZERO:  take_br = (st_q.r0 != '0);
            default:   take_br = 1'b0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.prn_v = 1'b0;
        st_d.bell  = 1'b0;
        if (!rst_n) begin
            st_d.ip     = '0;
            st_d.ir     = '0;
            st_d.r0     = '0;
            st_d.r1     = '0;
            st_d.halted = 1'b0;
            st_d.prn_d  = '0;
            if (load_en) begin
                st_d.mem[load_addr] = load_data;
                st_d.loading        = 1'b1;
            end else if (!st_q.loading) begin
                st_d.mem = '0;
            end
        end else begin
            st_d.loading = 1'b0;
            if (!st_q.halted) begin
                st_d.ir = op;
                st_d.ip = take_br ? arg : ip_seq;
                if (ctl.halt) begin
                    st_d.halted = 1'b1;
                end
                if (ctl.ring) begin
                    st_d.bell = 1'b1;
                end
                if (ctl.print) begin
                    st_d.prn_v = 1'b1;
                    st_d.prn_d = arg;
                end
                unique case (ctl.dst)
                    DST_R0:  st_d.r0 = alu_y;
                    DST_R1:  st_d.r1 = alu_y;
                    default: ;
                endcase
                if (ctl.mem_wr) begin
                    st_d.mem[arg] = ctl.wr_from_r1 ? st_q.r1 : st_q.r0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign print_valid = st_q.prn_v;
    assign print_data  = st_q.prn_d;
    assign bell        = st_q.bell;
    assign halted      = st_q.halted;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       print_valid,
    input logic [3:0] print_data,
    input logic       bell,
    input logic       halted
);
    // R1
    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (!halted && !print_valid && !bell))
        else $error("reset did not clear outputs");

    // R9
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted)
        else $error("halted dropped without reset");

    // R9
    a_r9_quiet_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> (!print_valid && !bell))
        else $error("activity after halt");

    // R6
    a_r6_print_bell_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(print_valid && bell))
        else $error("print and bell together");

    // R6
    a_r6_print_data_known: assert property (@(posedge clk) disable iff (!rst_n)
        print_valid |-> !$isunknown(print_data))
        else $error("unknown print data");
endmodule

bind nib_core nib_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .print_valid (print_valid),
    .print_data  (print_data),
    .bell        (bell),
    .halted      (halted)
);

// File: tb/nib_core_bench.sv
module nib_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [3:0] load_data = '0;
    logic       print_valid, bell, halted;
    logic [3:0] print_data;

    nib_core u_nib_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .print_valid(print_valid), .print_data(print_data),
        .bell(bell), .halted(halted)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] pr [32];
    int pr_at [32];
    int n_pr, n_bell, n_late, halt_k;
    bit done;

    // Program image: the leftmost hex digit is address 0. The low nibble holds the expected print.
    localparam logic [67:0] VEC [10] = '{
        {64'h44431B8800000000, 4'h4},  // R4 add
        {64'h33333442BB800000, 4'h3},  // R4 subtract
        {64'h5B48000000000000, 4'hF},  // R4 R0 decrement wrap
        {64'h66C5800000000000, 4'hE},  // R4 R1 decrement
        {64'h9FB5800000000007, 4'h7},  // R7 load R0
        {64'hAF1B680000000006, 4'h6},  // R7 load R1
        {64'hD481890000000000, 4'h9},  // R8 jump
        {64'hE481820000000000, 4'h2},  // R8 jump if zero taken
        {64'hF483000000000000, 4'h3},  // R8 jump if nonzero not taken
        {64'h5441B78000000000, 4'h1}   // R4 add wrap
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] prog, input bit use_load, input bit poke);
        @(negedge clk);
        rst_n   = 1'b0;
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        if (use_load) begin
            for (int i = 0; i < 16; i++) begin
                load_en   = 1'b1;
                load_addr = 4'(i);
                load_data = prog[63-4*i -: 4];
                @(negedge clk);
            end
        end
        load_en = 1'b0;
        rst_n   = 1'b1;
        n_pr = 0; n_bell = 0; n_late = 0; done = 1'b0; halt_k = -1;
        for (int k = 0; k < 400 && !done; k++) begin
            if (poke && k < 4) begin
                load_en = 1'b1; load_addr = 4'd4; load_data = 4'd9;
            end else begin
                load_en = 1'b0;
            end
            @(negedge clk);
            if (print_valid) begin
                if (n_pr < 32) begin pr[n_pr] = print_data; pr_at[n_pr] = k; end
                n_pr++;
            end
            if (bell) n_bell++;
            if (halted) begin done = 1'b1; halt_k = k; end
        end
        load_en = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (print_valid || bell || !halted) n_late++;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held low in reset
        check(!halted && !print_valid && !bell, "R1 reset outputs",
              {halted, print_valid, bell}, 0);

        for (int i = 0; i < 10; i++) begin
            run(VEC[i][67:4], 1'b1, 1'b0);
            check(n_pr == 1, $sformatf("R3 R6 vector %0d print count", i), n_pr, 1);
            check(pr[0] == VEC[i][3:0], $sformatf("R4 R7 R8 vector %0d value", i),
                  pr[0], VEC[i][3:0]);
            check(done && n_late == 0, $sformatf("R9 vector %0d halt", i), n_late, 0);
        end

        // R10: counting program with a self-modified operand (R7)
        run(64'h803B1F0000000000, 1'b1, 1'b0);
        check(n_pr == 16, "R10 print count", n_pr, 16);
        for (int j = 0; j < 16 && j < n_pr; j++) begin
            check(pr[j] == 4'(j), "R10 print order", pr[j], j);
            check(pr_at[j] == 4 * j, "R10 print spacing", pr_at[j], 4 * j);
        end
        check(halt_k == 64, "R9 halt cycle", halt_k, 64);
        check(n_late == 0, "R9 quiet after halt", n_late, 0);

        // R5: two bells, no print
        run(64'h7700000000000000, 1'b1, 1'b0);
        check(n_bell == 2, "R5 bell count", n_bell, 2);
        check(n_pr == 0, "R5 no print", n_pr, 0);
        check(halt_k == 2, "R9 halt after bells", halt_k, 2);

        // R3: operand fetch wraps from address 15 to 0
        run(64'hDF00000000000008, 1'b1, 1'b0);
        check(n_pr == 1 && pr[0] == 4'hD, "R3 pointer wrap print", pr[0], 13);

        // R2: load port ignored while running
        run(64'h3F08500000000000, 1'b1, 1'b1);
        check(n_pr == 1 && pr[0] == 4'h5, "R2 load ignored in run", pr[0], 5);

        // R1: reset with no load clears memory, so the core halts at once
        run(64'h0, 1'b0, 1'b0);
        check(halt_k == 0, "R1 memory cleared", halt_k, 0);
        check(n_pr == 0 && n_bell == 0, "R1 no activity", n_pr + n_bell, 0);

        summary();
        $finish;
    end
endmodule